// File: doc/BRIEF.md
# Conversion Run/Standby Controller

This block decides when temperature conversions run and when the surrounding logic may sleep. A configuration byte carries a standby bit. With the bit clear, the block runs continuously. It performs a conversion of fixed length, waits a fixed number of cycles, and then starts the next one. With the bit set, the converter, control-loop and fan-driver enables are all held low. The block still accepts configuration writes and one-shot commands in this state.

The conversion is modelled as a cycle counter. When the counter finishes, the block captures the value on the sample input into the temperature register in a single clock edge and raises a one-cycle load strobe. A standby request that arrives during a conversion aborts it. In that case the stored temperature keeps its old value. A one-shot command in standby runs exactly one conversion and then returns to the quiet standby state.

Top module: `conv_seq`

## Requirements
- R1: After reset the configuration byte reads 0x40 (standby), the temperature reads 0, and busy, load and all three enables are low.
- R2: A configuration write stores the write data into the configuration byte by the next cycle, in standby as well as in run mode.
- R3: While bit 6 of the configuration byte is 1 (standby), the control-loop and fan-driver enables are low, and the converter enable is low whenever no conversion is in progress.
- R4: Writing the configuration byte with bit 6 at 0 starts a conversion in the cycle after the byte is updated. Busy and the converter enable are high for exactly CONV_CYCLES cycles per conversion.
- R5: In run mode the next conversion starts exactly GAP_CYCLES cycles after busy falls. The control-loop and fan-driver enables stay high and the converter enable stays low during the gap.
- R6: On normal completion, load is high for the single cycle after busy falls, and in that cycle the temperature already holds the sample value present at the completing edge. The temperature changes at no other time.
- R7: A configuration write with bit 6 at 1 during a conversion aborts it. Busy is low in the next cycle, no load follows, and the temperature keeps its previous value. This holds for an abort at every cycle of the conversion.
- R8: A one-shot strobe in idle standby starts exactly one conversion of CONV_CYCLES cycles with one load. Afterwards the block returns to idle standby with all enables low.
- R9: A one-shot strobe during a conversion, or during the run-mode gap, has no effect on conversion length, gap length or load count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Configuration byte write strobe |
| cfg_data_i | input | 8 | Configuration write data, bit 6 = standby |
| oneshot_i | input | 1 | One-shot conversion command strobe |
| sample_i | input | DATA_W | Converter result captured at completion |
| cfg_o | output | 8 | Current configuration byte |
| temp_o | output | DATA_W | Temperature register |
| load_o | output | 1 | One-cycle strobe: temperature just updated |
| busy_o | output | 1 | Conversion in progress |
| conv_en_o | output | 1 | Converter enable |
| loop_en_o | output | 1 | Control-loop enable |
| fan_en_o | output | 1 | Fan-driver enable |

## Verification
The assertions check on every cycle that the standby bit keeps the loop and fan enables low, and that every load follows a busy run of exactly the conversion length. They also check that the temperature never moves without a load and that an abort write always suppresses the load. Only the bench scenarios can show the timing that spans a mode change. This covers the exact gap between run-mode conversions, the single conversion of a one-shot, the abort swept across every cycle of a conversion, and the one-shot strobes that must be ignored while busy or waiting.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  localparam int unsigned CFG_W    = 8;
  localparam int unsigned STBY_BIT = 6;

  typedef enum logic [1:0] {
    ST_SBY  = 2'd0,
    ST_WAIT = 2'd1,
    ST_CONV = 2'd2
  } seq_state_e;
endpackage

// File: rtl/conv_seq_cfg.sv
module conv_seq_cfg
  import conv_seq_pkg::*;
#(
  parameter logic [CFG_W-1:0] CFG_RST = 8'h40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] data_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             standby_o,
  output logic             stby_req_o
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= CFG_RST;
    else if (wr_i) cfg_q <= data_i;
  end

  assign cfg_o      = cfg_q;
  assign standby_o  = cfg_q[STBY_BIT];
  // a write that sets standby acts in the same edge (abort path)
  assign stby_req_o = wr_i & data_i[STBY_BIT];
endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
  import conv_seq_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 16,
  parameter int unsigned GAP_CYCLES  = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       standby_i,
  input  logic       stby_req_i,
  input  logic       oneshot_i,
  output seq_state_e state_o,
  output logic       done_o
);
  localparam int unsigned MAX_C = (CONV_CYCLES > GAP_CYCLES) ? CONV_CYCLES : GAP_CYCLES;
  localparam int unsigned CNT_W = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] LAST_CONV = CNT_W'(CONV_CYCLES - 1);
  localparam logic [CNT_W-1:0] LAST_GAP  = CNT_W'(GAP_CYCLES - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             conv_last;

  assign conv_last = (state_q == ST_CONV) && (cnt_q == LAST_CONV);
  assign done_o    = conv_last && !stby_req_i;
  assign state_o   = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SBY;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_SBY: begin
          cnt_q <= '0;
          if (oneshot_i || (!standby_i && !stby_req_i)) state_q <= ST_CONV;
        end
        ST_CONV: begin
          if (stby_req_i) begin
            state_q <= ST_SBY;
            cnt_q   <= '0;
          end else if (conv_last) begin
            state_q <= standby_i ? ST_SBY : ST_WAIT;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WAIT: begin
          if (stby_req_i || standby_i) begin
            state_q <= ST_SBY;
            cnt_q   <= '0;
          end else if (cnt_q == LAST_GAP) begin
            state_q <= ST_CONV;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          state_q <= ST_SBY;
          cnt_q   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/conv_seq_result.sv
module conv_seq_result #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic [DATA_W-1:0] temp_o,
  output logic              load_o
);
  logic [DATA_W-1:0] temp_q;
  logic              load_q;

  // whole word in one edge, only on clean completion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      temp_q <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= commit_i;
      if (commit_i) temp_q <= sample_i;
    end
  end

  assign temp_o = temp_q;
  assign load_o = load_q;
endmodule

// File: rtl/conv_seq.sv
module conv_seq
  import conv_seq_pkg::*;
#(
  parameter int unsigned       DATA_W      = 8,
  parameter int unsigned       CONV_CYCLES = 16,
  parameter int unsigned       GAP_CYCLES  = 32,
  parameter logic [CFG_W-1:0]  CFG_RST     = 8'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [7:0]        cfg_data_i,
  input  logic              oneshot_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic [7:0]        cfg_o,
  output logic [DATA_W-1:0] temp_o,
  output logic              load_o,
  output logic              busy_o,
  output logic              conv_en_o,
  output logic              loop_en_o,
  output logic              fan_en_o
);
  logic       standby;
  logic       stby_req;
  logic       done;
  seq_state_e state;

  conv_seq_cfg #(.CFG_RST(CFG_RST)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (cfg_wr_i),
    .data_i     (cfg_data_i),
    .cfg_o      (cfg_o),
    .standby_o  (standby),
    .stby_req_o (stby_req)
  );

  conv_seq_ctrl #(.CONV_CYCLES(CONV_CYCLES), .GAP_CYCLES(GAP_CYCLES)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .standby_i  (standby),
    .stby_req_i (stby_req),
    .oneshot_i  (oneshot_i),
    .state_o    (state),
    .done_o     (done)
  );

  conv_seq_result #(.DATA_W(DATA_W)) u_res (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (done),
    .sample_i (sample_i),
    .temp_o   (temp_o),
    .load_o   (load_o)
  );

  assign busy_o    = (state == ST_CONV);
  assign conv_en_o = (state == ST_CONV);
  // one-shot conversions in standby power the converter only
  assign loop_en_o = (state != ST_SBY) && !standby;
  assign fan_en_o  = (state != ST_SBY) && !standby;
endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CONV_CYCLES = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_wr_i,
  input logic [7:0]        cfg_data_i,
  input logic              oneshot_i,
  input logic [7:0]        cfg_o,
  input logic [DATA_W-1:0] temp_o,
  input logic              load_o,
  input logic              busy_o,
  input logic              conv_en_o,
  input logic              loop_en_o,
  input logic              fan_en_o
);
  localparam int unsigned LEN_W = $clog2(CONV_CYCLES + 1) + 1;

  logic [LEN_W-1:0] busy_len;
  logic             busy_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_len <= '0;
      busy_d   <= 1'b0;
    end else begin
      busy_d <= busy_o;
      if (busy_o) busy_len <= busy_d ? busy_len + 1'b1 : LEN_W'(1);
    end
  end

  AST_CFG_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i |=> cfg_o == $past(cfg_data_i)); // R2
  AST_STBY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_o[6] |-> !loop_en_o && !fan_en_o); // R3
  AST_STBY_NO_CONV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_o[6] && !busy_o) |-> !conv_en_o); // R3
  AST_CONV_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> busy_len == LEN_W'(CONV_CYCLES)); // R4
  AST_LOAD_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> busy_d && !busy_o); // R6
  AST_TEMP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_o |-> temp_o == $past(temp_o)); // R6
  AST_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cfg_wr_i && cfg_data_i[6]) |=> !busy_o && !load_o); // R7
  AST_ONESHOT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cfg_o[6] && oneshot_i && !cfg_wr_i) |=> busy_o); // R8
endmodule

bind conv_seq conv_seq_chk #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_wr_i   (cfg_wr_i),
  .cfg_data_i (cfg_data_i),
  .oneshot_i  (oneshot_i),
  .cfg_o      (cfg_o),
  .temp_o     (temp_o),
  .load_o     (load_o),
  .busy_o     (busy_o),
  .conv_en_o  (conv_en_o),
  .loop_en_o  (loop_en_o),
  .fan_en_o   (fan_en_o)
);

// File: tb/conv_seq_bench.sv
`timescale 1ns/1ps
module conv_seq_bench;
  localparam int N = 4;
  localparam int G = 3;
  localparam int DW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_wr_i = 1'b0;
  logic [7:0]    cfg_data_i = 8'h00;
  logic          oneshot_i = 1'b0;
  logic [DW-1:0] sample_i = 8'h11;
  logic [7:0]    cfg_o;
  logic [DW-1:0] temp_o;
  logic          load_o, busy_o, conv_en_o, loop_en_o, fan_en_o;

  int total = 0;
  int bad = 0;
  int loads = 0;
  bit finished = 1'b0;
  bit mon_on = 1'b0;
  logic [DW-1:0] exp_temp = '0;
  logic [DW-1:0] prev_sample = '0;

  always #5 clk_i = ~clk_i;

  conv_seq #(.DATA_W(DW), .CONV_CYCLES(N), .GAP_CYCLES(G)) u_conv_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_wr_i(cfg_wr_i), .cfg_data_i(cfg_data_i),
    .oneshot_i(oneshot_i), .sample_i(sample_i), .cfg_o(cfg_o), .temp_o(temp_o),
    .load_o(load_o), .busy_o(busy_o), .conv_en_o(conv_en_o),
    .loop_en_o(loop_en_o), .fan_en_o(fan_en_o));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // new sample each cycle, changed well after the rising edge
  initial forever begin
    @(posedge clk_i);
    #2 sample_i = sample_i + 8'd37;
  end

  // R6 reference: temp follows the sample seen at the completing edge
  always @(negedge clk_i) begin
    if (mon_on) begin
      if (load_o) begin
        loads++;
        exp_temp = prev_sample;
      end
      chk("R6 temp", int'(temp_o), int'(exp_temp));
    end
    prev_sample = sample_i;
  end

  task automatic nclk();
    @(negedge clk_i);
    #1;
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    cfg_wr_i = 1'b1;
    cfg_data_i = v;
    nclk();
    cfg_wr_i = 1'b0;
  endtask

  task automatic pulse_os();
    oneshot_i = 1'b1;
    nclk();
    oneshot_i = 1'b0;
  endtask

  task automatic busy_run(output int n);
    n = 0;
    while (busy_o && n < 100) begin
      if (!conv_en_o) chk("R4 conv_en", 0, 1);
      n++;
      nclk();
    end
  endtask

  task automatic gap_run(input bit os_mid, output int n);
    n = 0;
    while (!busy_o && n < 100) begin
      chk("R5 loop/fan/conv", int'({loop_en_o, fan_en_o, conv_en_o}), 6);
      if (os_mid && n == 1) oneshot_i = 1'b1;  // R9 in gap
      n++;
      nclk();
      oneshot_i = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int len, gap, l0;
    repeat (3) nclk();
    rst_ni = 1'b1;
    nclk();
    mon_on = 1'b1;
    // R1
    chk("R1 cfg", int'(cfg_o), 8'h40);
    chk("R1 temp", int'(temp_o), 0);
    chk("R1 busy/load/en", int'({busy_o, load_o, conv_en_o, loop_en_o, fan_en_o}), 0);

    // R3 idle standby stays quiet
    for (int i = 0; i < 20; i++) begin
      if (busy_o | conv_en_o | loop_en_o | fan_en_o) chk("R3 quiet", 1, 0);
      nclk();
    end
    chk("R3 no loads", loads, 0);

    // R2 write accepted in standby
    wr_cfg(8'h55);
    chk("R2 cfg standby", int'(cfg_o), 8'h55);
    chk("R2 still idle", int'(busy_o), 0);

    // R8 one-shot in standby, repeated for several samples
    for (int k = 0; k < 3; k++) begin
      l0 = loads;
      pulse_os();
      chk("R8 busy start", int'(busy_o), 1);
      chk("R3 loop/fan off in one-shot", int'({loop_en_o, fan_en_o}), 0);
      if (k == 1) begin
        nclk();
        pulse_os();  // R9 one-shot while busy
        busy_run(len);
        len += 2;
      end else begin
        busy_run(len);
      end
      chk("R8 one-shot length", len, N);
      chk("R6 load after busy", int'(load_o), 1);
      repeat (N + G + 4) nclk();
      chk("R8 single load", loads - l0, 1);
      chk("R8 back to quiet", int'({busy_o, conv_en_o, loop_en_o, fan_en_o}), 0);
    end

    // R4 run start timing
    wr_cfg(8'h15);
    chk("R2 cfg run", int'(cfg_o), 8'h15);
    chk("R4 not yet busy", int'(busy_o), 0);
    nclk();
    chk("R4 busy next cycle", int'(busy_o), 1);
    for (int p = 0; p < 4; p++) begin
      busy_run(len);
      chk("R4 run length", len, N);
      chk("R6 load pulse", int'(load_o), 1);
      gap_run(p == 2, gap);
      chk("R5 gap length", gap, G);
    end

    // R3 standby write in gap
    busy_run(len);
    nclk();
    wr_cfg(8'h40);
    chk("R3 enables off", int'({busy_o, conv_en_o, loop_en_o, fan_en_o}), 0);

    // R7 abort at every conversion cycle
    for (int k = 0; k < N; k++) begin
      l0 = loads;
      wr_cfg(8'h00);
      nclk();
      chk("R7 started", int'(busy_o), 1);
      for (int j = 0; j < k; j++) nclk();
      wr_cfg(8'h40);
      chk("R7 busy dropped", int'(busy_o), 0);
      chk("R7 no load strobe", int'(load_o), 0);
      repeat (N + G) nclk();
      chk("R7 no loads", loads - l0, 0);
      chk("R3 quiet after abort", int'({conv_en_o, loop_en_o, fan_en_o}), 0);
    end
    chk("R2 cfg retained", int'(cfg_o), 8'h40);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule